// File: doc/BRIEF.md
# Dual-Mode Serial Transmitter

This block is one transmit channel that sends bytes either as asynchronous UART frames or as an 8-bit clocked synchronous stream. A free-running 4-bit divider counts pulses of a prescaled serial base clock (`baseTick`, a one-cycle enable in the system clock domain). Every sixteenth pulse becomes a UART bit clock. In synchronous mode each bit is launched on a shift-clock edge. The block can generate the shift clock itself from `baseTick`, or it can follow an external clock on `sclkIn` on a chosen edge.

Software writes bytes through a simple write strobe. With single buffering the byte goes straight into the shift register. With double buffering it goes into a one-entry holding buffer and moves to the shift register as soon as the shifter is free. The choice changes when the transmit interrupt pulse fires and what the buffer-empty flag tracks. A write that finds no free storage is dropped and sets a sticky overrun flag.

Top module: `dual_mode_tx`

## Requirements
- R1: In UART mode a bit clock occurs on every 16th `baseTick` pulse counted from reset. A loaded frame starts on the first bit clock after loading, and `txd` changes only on bit clocks.
- R2: A UART frame on `txd` is a 0 start bit, then the 8 data bits LSB first, then a 1 stop bit, each held for one bit period. `txd` idles at 1.
- R3: With `dblBufEn`=0 a write loads the shift register and clears `bufEmpty`. On the bit clock that ends the stop bit, `bufEmpty` returns to 1 and `txIrq` pulses.
- R4: With `dblBufEn`=1 a write fills the holding buffer and clears `bufEmpty`. On the next clock edge at which the shifter is free, the byte moves into the shifter, `txIrq` pulses and `bufEmpty` is set at that same edge. No pulse occurs at the end of the frame.
- R5: In synchronous mode with `sclkIsInput`=0, `sclkOut` idles at 1. Each `baseTick` during a transfer toggles it. Data bits go out LSB first at each falling edge, and the transfer completes at the rising edge after the 8th bit.
- R6: In synchronous mode with `sclkIsInput`=1, `sclkIn` passes through a two-flop synchronizer. With `sclkFallSel`=0 bits launch on rising edges; with `sclkFallSel`=1 they launch on falling edges. The transfer completes on the opposite edge after the 8th bit, and `txd` does not change on the non-selected edges before that.
- R7: A write that finds no room (the shifter is busy in single mode, or the buffer is held in double mode) leaves the transmitted data unchanged and sets `overrun`, which stays at 1 until reset.
- R8: `txIrq` is high for exactly one system clock cycle per event.
- R9: After reset: `txd`=1, `sclkOut`=1, `bufEmpty`=1, `txIrq`=0, `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | One-cycle pulse of the prescaled serial base clock |
| modeSync | input | 1 | 1 = clocked synchronous mode, 0 = UART mode |
| sclkIsInput | input | 1 | Synchronous mode: 1 = follow `sclkIn`, 0 = drive `sclkOut` |
| sclkFallSel | input | 1 | External clock: 1 = launch on falling edges, 0 = on rising edges |
| dblBufEn | input | 1 | 1 = write through the holding buffer |
| wrEn | input | 1 | Write strobe for transmit data |
| wrData | input | 8 | Byte to transmit |
| sclkIn | input | 1 | External shift clock, asynchronous |
| sclkOut | output | 1 | Generated shift clock |
| txd | output | 1 | Serial data out |
| bufEmpty | output | 1 | Transmit storage can take a new byte |
| txIrq | output | 1 | Transmit interrupt pulse |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
The bench writes bytes a few base ticks away from a divider wrap. If the divider were reset on a write, or the frame started on the write itself, the start bit would appear at the wrong tick. It compares every base tick of each UART frame against a computed bit schedule, so a swapped bit order or a missing stop bit shows up as a `txd` mismatch. Double buffering is checked cycle by cycle around the buffer-to-shifter move: a design that fires the interrupt at frame end, or leaves `bufEmpty` low until then, fails. External-clock runs with both edge selections check that `txd` holds across the non-selected edge. A third write into full storage must not corrupt the next frame and must raise `overrun`.

// File: rtl/tx_pkg.sv
package tx_pkg;
  // Strobes issued by control to the datapath, one cycle each.
  typedef struct packed {
    logic loadWr;    // write goes straight into the shifter
    logic loadBuf;   // write goes into the holding buffer
    logic moveBuf;   // holding buffer -> shifter
    logic startBit;  // put first frame bit on txd
    logic stepBit;   // put next frame bit on txd
    logic finish;    // frame done, return txd to idle
    logic sclkFall;  // drive generated shift clock low
    logic sclkRise;  // drive generated shift clock high
  } txStrobes_t;
endpackage

// File: rtl/tx_datapath.sv
module tx_datapath
  import tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        st,
  input  logic              modeSync,
  input  logic [DATA_W-1:0] wrData,
  output logic              txd,
  output logic              sclkOut
);
  localparam int FRAME_W = DATA_W + 2;

  logic [DATA_W-1:0]  bufReg;
  logic [FRAME_W-1:0] shReg;

  // UART: stop, data, start (start in bit 0). Sync: data only, padded with ones.
  function automatic logic [FRAME_W-1:0] frameOf(input logic [DATA_W-1:0] d,
                                                 input logic sync);
    return sync ? {2'b11, d} : {1'b1, d, 1'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufReg  <= '0;
      shReg   <= '1;
      txd     <= 1'b1;
      sclkOut <= 1'b1;
    end else begin
      if (st.loadBuf) bufReg <= wrData;

      if (st.loadWr) begin
        shReg <= frameOf(wrData, modeSync);
      end else if (st.moveBuf) begin
        shReg <= frameOf(bufReg, modeSync);
      end else if (st.startBit || st.stepBit) begin
        txd   <= shReg[0];
        shReg <= {1'b1, shReg[FRAME_W-1:1]};
      end

      if (st.finish) txd <= 1'b1;

      if (st.sclkFall)      sclkOut <= 1'b0;
      else if (st.sclkRise) sclkOut <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic       modeSync,
  input  logic       sclkIsInput,
  input  logic       sclkFallSel,
  input  logic       dblBufEn,
  input  logic       wrEn,
  input  logic       sclkIn,
  input  logic       sclkOutFb,
  output txStrobes_t st,
  output logic       bufEmpty,
  output logic       txIrq,
  output logic       overrun
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] UART_LAST = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(DATA_W - 1);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             bitTick, shiftFull, bufFull, active;
  logic             sync1, sync2, syncPrev, extRise, extFall;
  logic             intSync, extSync, shiftEdge, doneEdge, wrDrop;

  assign bitTick = baseTick && (divCnt == '1);
  assign extRise = sync2 && !syncPrev;
  assign extFall = !sync2 && syncPrev;
  assign intSync = modeSync && !sclkIsInput;
  assign extSync = modeSync && sclkIsInput;

  always_comb begin
    if (!modeSync) begin
      shiftEdge = bitTick;
      doneEdge  = bitTick;
    end else if (extSync) begin
      shiftEdge = sclkFallSel ? extFall : extRise;
      doneEdge  = sclkFallSel ? extRise : extFall;
    end else begin
      shiftEdge = baseTick && sclkOutFb;
      doneEdge  = baseTick && !sclkOutFb;
    end

    st          = '0;
    st.moveBuf  = dblBufEn && bufFull && !shiftFull;
    st.loadWr   = wrEn && !dblBufEn && !shiftFull;
    st.loadBuf  = wrEn && dblBufEn && (!bufFull || st.moveBuf);
    st.startBit = !active && shiftFull && shiftEdge;
    st.stepBit  = active && (bitCnt != '0) && shiftEdge;
    st.finish   = active && (bitCnt == '0) && doneEdge;
    st.sclkFall = intSync && (st.startBit || st.stepBit);
    st.sclkRise = intSync && baseTick && !sclkOutFb;
    wrDrop      = wrEn && !(st.loadWr || st.loadBuf);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      bitCnt    <= '0;
      shiftFull <= 1'b0;
      bufFull   <= 1'b0;
      active    <= 1'b0;
      sync1     <= 1'b0;
      sync2     <= 1'b0;
      syncPrev  <= 1'b0;
      bufEmpty  <= 1'b1;
      txIrq     <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (baseTick) divCnt <= divCnt + 1'b1;

      sync1    <= sclkIn;
      sync2    <= sync1;
      syncPrev <= sync2;

      if (st.loadWr || st.moveBuf) shiftFull <= 1'b1;
      else if (st.finish)          shiftFull <= 1'b0;

      if (st.loadBuf)      bufFull <= 1'b1;
      else if (st.moveBuf) bufFull <= 1'b0;

      if (st.startBit) begin
        active <= 1'b1;
        bitCnt <= modeSync ? SYNC_LAST : UART_LAST;
      end else if (st.stepBit) begin
        bitCnt <= bitCnt - 1'b1;
      end else if (st.finish) begin
        active <= 1'b0;
      end

      if (dblBufEn) begin
        if (st.loadBuf)      bufEmpty <= 1'b0;
        else if (st.moveBuf) bufEmpty <= 1'b1;
      end else begin
        if (st.loadWr)      bufEmpty <= 1'b0;
        else if (st.finish) bufEmpty <= 1'b1;
      end

      txIrq   <= dblBufEn ? st.moveBuf : st.finish;
      overrun <= overrun || wrDrop;
    end
  end
endmodule

// File: rtl/dual_mode_tx.sv
module dual_mode_tx
  import tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic              modeSync,
  input  logic              sclkIsInput,
  input  logic              sclkFallSel,
  input  logic              dblBufEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              txd,
  output logic              bufEmpty,
  output logic              txIrq,
  output logic              overrun
);
  txStrobes_t strobes;

  tx_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .modeSync(modeSync),
    .sclkIsInput(sclkIsInput), .sclkFallSel(sclkFallSel), .dblBufEn(dblBufEn),
    .wrEn(wrEn), .sclkIn(sclkIn), .sclkOutFb(sclkOut), .st(strobes),
    .bufEmpty(bufEmpty), .txIrq(txIrq), .overrun(overrun)
  );

  tx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .modeSync(modeSync),
    .wrData(wrData), .txd(txd), .sclkOut(sclkOut)
  );
endmodule

// File: rtl/dual_mode_tx_chk.sv
module dual_mode_tx_chk (
  input logic clk,
  input logic rstN,
  input logic baseTick,
  input logic modeSync,
  input logic dblBufEn,
  input logic txd,
  input logic sclkOut,
  input logic txIrq,
  input logic bufEmpty,
  input logic overrun
);
  a_r8_irq_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  a_r5_sclk_high_in_uart: assert property (@(posedge clk) disable iff (!rstN)
    !modeSync |-> sclkOut);

  a_r1_txd_moves_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSync && !$stable(txd)) |-> $past(baseTick));

  a_r3_empty_with_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    (!dblBufEn && $rose(bufEmpty)) |-> txIrq);

  a_r4_empty_with_irq_dbl: assert property (@(posedge clk) disable iff (!rstN)
    (dblBufEn && $rose(bufEmpty)) |-> txIrq);
endmodule

bind dual_mode_tx dual_mode_tx_chk u_chk (.*);

// File: tb/dual_mode_tx_tb.sv
module dual_mode_tx_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTick = 1'b0;
  logic       modeSync = 1'b0;
  logic       sclkIsInput = 1'b0;
  logic       sclkFallSel = 1'b0;
  logic       dblBufEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       sclkIn = 1'b0;
  logic       sclkOut, txd, bufEmpty, txIrq, overrun;

  int nChecks = 0;
  int nFail = 0;
  int k = 0;         // base ticks since reset
  int irqCount = 0;

  always #4 clk = ~clk;  // 125 MHz

  dual_mode_tx u_dut (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .modeSync(modeSync),
    .sclkIsInput(sclkIsInput), .sclkFallSel(sclkFallSel), .dblBufEn(dblBufEn),
    .wrEn(wrEn), .wrData(wrData), .sclkIn(sclkIn), .sclkOut(sclkOut),
    .txd(txd), .bufEmpty(bufEmpty), .txIrq(txIrq), .overrun(overrun)
  );

  always @(negedge clk) if (rstN && txIrq === 1'b1) irqCount++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic tick();
    baseTick = 1'b1;
    cyc();
    baseTick = 1'b0;
    k++;
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1;
    wrData = d;
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic doReset(input logic sync, input logic ext, input logic fallSel,
                         input logic dbl);
    rstN = 1'b0;
    modeSync = sync;
    sclkIsInput = ext;
    sclkFallSel = fallSel;
    dblBufEn = dbl;
    sclkIn = fallSel;
    cyc();
    cyc();
    rstN = 1'b1;
    k = 0;
    cyc();
  endtask

  // Runs one UART frame from an already loaded shifter up to its end.
  task automatic runUart(input logic [7:0] d, input logic irqAtEnd);
    int bitIdx = 0;
    logic expTxd;
    while (bitIdx < 11) begin
      tick();
      if (k % 16 == 0) bitIdx++;
      if (bitIdx == 0)      expTxd = 1'b1;
      else if (bitIdx == 1) expTxd = 1'b0;
      else if (bitIdx <= 9) expTxd = d[bitIdx-2];
      else                  expTxd = 1'b1;
      chk("R2 uart txd", txd, expTxd);
      if (bitIdx == 11) chk("R3/R4 irq at frame end", txIrq, irqAtEnd);
      else              chk("R8 no irq mid frame", txIrq, 1'b0);
    end
    if (irqAtEnd) chk("R3 bufEmpty at frame end", bufEmpty, 1'b1);
  endtask

  task automatic runSyncInt(input logic [7:0] d);
    for (int i = 1; i <= 16; i++) begin
      tick();
      chk("R5 sclkOut level", sclkOut, (i % 2 == 1) ? 1'b0 : 1'b1);
      if (i % 2 == 1)  chk("R5 bit on falling edge", txd, d[(i-1)/2]);
      else if (i < 16) chk("R5 bit held on rising edge", txd, d[i/2-1]);
      else             chk("R5 idle after transfer", txd, 1'b1);
      chk("R3 irq only at finish", txIrq, (i == 16) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic runSyncExt(input logic [7:0] d);
    int irq0 = irqCount;
    for (int e = 0; e < 16; e++) begin
      sclkIn = ~sclkIn;
      repeat (4) cyc();
      if (e % 2 == 0) begin
        chk("R6 bit on selected edge", txd, d[e/2]);
        chk("R6 no finish yet", irqCount - irq0, 0);
      end else if (e < 15) begin
        chk("R6 hold on other edge", txd, d[(e-1)/2]);
        chk("R6 no finish yet", irqCount - irq0, 0);
      end else begin
        chk("R6 idle after transfer", txd, 1'b1);
        chk("R6 finish on opposite edge", irqCount - irq0, 1);
      end
      chk("R6 sclkOut untouched", sclkOut, 1'b1);
    end
  endtask

  initial begin
    #(8 * 190000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] bytes [4] = '{8'h00, 8'hFF, 8'h01, 8'h80};
    @(negedge clk);
    #1;
    // Reset state
    doReset(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 txd", txd, 1'b1);
    chk("R9 sclkOut", sclkOut, 1'b1);
    chk("R9 bufEmpty", bufEmpty, 1'b1);
    chk("R9 txIrq", txIrq, 1'b0);
    chk("R9 overrun", overrun, 1'b0);

    // UART, single buffer, write off a divider boundary
    repeat (5) tick();
    wr(8'hA5);
    chk("R3 write clears bufEmpty", bufEmpty, 1'b0);
    chk("R7 no overrun yet", overrun, 1'b0);
    wr(8'h3C);
    chk("R7 overrun on busy shifter", overrun, 1'b1);
    runUart(8'hA5, 1'b1);
    cyc();
    chk("R8 irq drops", txIrq, 1'b0);
    foreach (bytes[i]) begin
      wr(bytes[i]);
      chk("R3 write clears bufEmpty", bufEmpty, 1'b0);
      runUart(bytes[i], 1'b1);
    end
    chk("R7 overrun sticky", overrun, 1'b1);

    // UART, double buffer
    doReset(1'b0, 1'b0, 1'b0, 1'b1);
    repeat (3) tick();
    wr(8'h5A);
    chk("R4 write clears bufEmpty", bufEmpty, 1'b0);
    chk("R4 no irq on write", txIrq, 1'b0);
    cyc();
    chk("R4 irq on move", txIrq, 1'b1);
    chk("R4 bufEmpty on move", bufEmpty, 1'b1);
    cyc();
    chk("R8 irq one cycle", txIrq, 1'b0);
    wr(8'hC3);
    chk("R4 second write clears bufEmpty", bufEmpty, 1'b0);
    chk("R7 no overrun yet", overrun, 1'b0);
    wr(8'h11);
    chk("R7 overrun when both full", overrun, 1'b1);
    runUart(8'h5A, 1'b0);
    chk("R4 buffer still held at frame end", bufEmpty, 1'b0);
    cyc();
    chk("R4 irq on move after frame", txIrq, 1'b1);
    chk("R4 bufEmpty on move after frame", bufEmpty, 1'b1);
    runUart(8'hC3, 1'b0);
    chk("R4 bufEmpty stays set", bufEmpty, 1'b1);
    chk("R7 overrun sticky", overrun, 1'b1);

    // Synchronous, generated shift clock
    doReset(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5 sclkOut idle", sclkOut, 1'b1);
    wr(8'h96);
    runSyncInt(8'h96);
    wr(8'h4B);
    runSyncInt(8'h4B);
    tick();
    chk("R5 sclkOut idle after", sclkOut, 1'b1);

    // Synchronous, external clock, rising then falling launch edge
    doReset(1'b1, 1'b1, 1'b0, 1'b0);
    wr(8'hB2);
    runSyncExt(8'hB2);
    doReset(1'b1, 1'b1, 1'b1, 1'b0);
    wr(8'h6D);
    runSyncExt(8'h6D);
    chk("R7 no overrun in clean run", overrun, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule